// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address stream for a four-beat burst inside a synchronous burst memory. A burst opens when either of two start strobes is high at a rising clock edge: the full input address is captured and the beat count restarts at zero. On each later edge where the advance enable is high, the beat count steps by one. The low two bits of the output address are then formed from the captured low bits and the beat count, in linear or interleaved order. The upper address bits stay fixed for the whole burst.

The order-select input is not clocked. It feeds the output mapping directly, so a change on it shows on the output address within the same cycle. A one-bit flag marks the last beat of the current group of four. Advancing past that beat wraps back to the captured start address; the burst never crosses into the neighbouring block of four. The memory array, the data path and the write control sit outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is high at a rising edge, the beat count and the captured address are cleared, so after that edge cur_addr is 0 and last_beat is 0.
- R2: When start_pri is high at a rising edge, cur_addr equals the addr_in of that edge after the edge, and the beat count is 0.
- R3: When start_sec is high at a rising edge, with start_pri low, cur_addr equals the addr_in of that edge after the edge, and the beat count is 0.
- R4: When both strobes are high at the same edge, the address is loaded once and the beat count is 0. A strobe overrides adv_en at the same edge.
- R5: With both strobes low, an edge with adv_en high steps the beat count by one. An edge with adv_en low leaves cur_addr unchanged.
- R6: With lin_order = 1 (linear order), the low two bits of cur_addr are (start low bits + beat) mod 4.
- R7: With lin_order = 0 (interleaved order), the low two bits of cur_addr are (start low bits) XOR beat.
- R8: lin_order is not registered. A change on it changes cur_addr with no clock edge in between.
- R9: Bits above bit 1 of cur_addr keep their captured value across every advance. The fourth advance after a load returns cur_addr to the start address.
- R10: last_beat is 1 exactly when the beat count is 3. It is 0 right after a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_pri | input | 1 | Primary burst start strobe, active high |
| start_sec | input | 1 | Secondary burst start strobe, active high |
| adv_en | input | 1 | Step to the next beat when high |
| lin_order | input | 1 | Beat order: 1 linear, 0 interleaved (unclocked) |
| addr_in | input | ADDR_W | Start address captured on a strobe |
| cur_addr | output | ADDR_W | Current burst address |
| last_beat | output | 1 | High while the beat count is 3 |

## Verification
The clocked properties assume that lin_order holds steady across a cycle whenever cur_addr is to be compared with its earlier value. Because the order input is unclocked, a change on it legally moves the output between edges. The hold property therefore checks stability only when the order input is also stable. The bench changes lin_order only inside the scenario that tests it and drives every other input one time unit after the rising edge. All samples are taken at that same point, clear of the edge.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // beat ordering, value taken from the unclocked order input
  typedef enum logic {
    ORD_INTERLEAVED = 1'b0,
    ORD_LINEAR      = 1'b1
  } order_e;

  // which strobe opened the burst; primary wins a tie
  typedef enum logic [1:0] {
    LD_NONE      = 2'd0,
    LD_PRIMARY   = 2'd1,
    LD_SECONDARY = 2'd2
  } load_src_e;

endpackage

// File: rtl/bsq_capture.sv
module bsq_capture #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
    end
  end

endmodule

// File: rtl/bsq_beat_counter.sv
module bsq_beat_counter #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  input  logic              step,
  output logic [BEAT_W-1:0] beat_q,
  output logic              last_q
);

  localparam logic [BEAT_W-1:0] BEAT_LAST = '1;
  localparam logic [BEAT_W-1:0] BEAT_ONE  = BEAT_W'(1);

  logic [BEAT_W-1:0] beat_nxt;

  assign beat_nxt = beat_q + BEAT_ONE;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else if (restart) begin
      beat_q <= '0;
      last_q <= 1'b0;
    end else if (step) begin
      beat_q <= beat_nxt;           // wraps inside the group
      last_q <= (beat_nxt == BEAT_LAST);
    end
  end

endmodule

// File: rtl/bsq_order_map.sv
module bsq_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] low_out
);

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  generate
    if (BEAT_W == 1) begin : g_one_bit
      // both orders coincide for a two-beat group
      assign lin_low = start_low ^ beat;
      assign ilv_low = start_low ^ beat;
    end else begin : g_multi_bit
      assign lin_low = start_low + beat;   // modulo 2**BEAT_W
      assign ilv_low = start_low ^ beat;
    end
  endgenerate

  always_comb begin
    case (order)
      ORD_LINEAR: low_out = lin_low;
      default:    low_out = ilv_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_pri,
  input  logic              start_sec,
  input  logic              adv_en,
  input  logic              lin_order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              last_beat
);

  localparam int HI_W = ADDR_W - BEAT_W;

  load_src_e         load_src;
  logic              load;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_bits;
  order_e            order;

  always_comb begin
    if (start_pri) begin
      load_src = LD_PRIMARY;
    end else if (start_sec) begin
      load_src = LD_SECONDARY;
    end else begin
      load_src = LD_NONE;
    end
  end

  assign load  = (load_src != LD_NONE);
  assign order = order_e'(lin_order);

  bsq_capture #(.ADDR_W(ADDR_W)) u_capture (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .addr_in (addr_in),
    .base_q  (base_q)
  );

  bsq_beat_counter #(.BEAT_W(BEAT_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .restart (load),
    .step    (adv_en),
    .beat_q  (beat_q),
    .last_q  (last_beat)
  );

  bsq_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_low (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .order     (order),
    .low_out   (low_bits)
  );

  assign cur_addr = {base_q[ADDR_W-1:BEAT_W], low_bits};

  initial begin
    if (HI_W < 1) $error("ADDR_W must exceed BEAT_W");
  end

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start_pri,
  input logic              start_sec,
  input logic              adv_en,
  input logic              lin_order,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              last_beat
);

  // R2
  a_r2_pri_load: assert property (@(posedge clk) disable iff (rst)
    start_pri |=> cur_addr == $past(addr_in));

  // R3
  a_r3_sec_load: assert property (@(posedge clk) disable iff (rst)
    start_sec |=> cur_addr == $past(addr_in));

  // R5
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!start_pri && !start_sec && !adv_en) |=>
      (!$stable(lin_order) || $stable(cur_addr)));

  // R9
  a_r9_upper_fixed: assert property (@(posedge clk) disable iff (rst)
    (!start_pri && !start_sec) |=>
      cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));

  // R10
  a_r10_clear_on_load: assert property (@(posedge clk) disable iff (rst)
    (start_pri || start_sec) |=> !last_beat);

  // R10
  a_r10_leave_last: assert property (@(posedge clk) disable iff (rst)
    (last_beat && adv_en) |=> !last_beat);

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start_pri (start_pri),
  .start_sec (start_sec),
  .adv_en    (adv_en),
  .lin_order (lin_order),
  .addr_in   (addr_in),
  .cur_addr  (cur_addr),
  .last_beat (last_beat)
);

// File: tb/burst_addr_seq_bench.sv
module burst_addr_seq_bench;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst;
  logic          start_pri;
  logic          start_sec;
  logic          adv_en;
  logic          lin_order;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] cur_addr;
  logic          last_beat;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BEAT_W(2)) u_burst_addr_seq (
    .clk       (clk),
    .rst       (rst),
    .start_pri (start_pri),
    .start_sec (start_sec),
    .adv_en    (adv_en),
    .lin_order (lin_order),
    .addr_in   (addr_in),
    .cur_addr  (cur_addr),
    .last_beat (last_beat)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, int beat, logic lin);
    logic [1:0] b;
    logic [1:0] lo;
    b  = 2'(beat);
    lo = lin ? 2'(base[1:0] + b) : (base[1:0] ^ b);
    return {base[AW-1:2], lo};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    start_pri = 1'b0;
    start_sec = 1'b0;
    adv_en    = 1'b0;
  endtask

  task automatic load(logic p, logic s, logic [AW-1:0] a);
    start_pri = p;
    start_sec = s;
    addr_in   = a;
    tick();
    idle();
  endtask

  task automatic t_reset();
    rst = 1'b1; idle(); lin_order = 1'b1; addr_in = 17'h1_5555;
    tick(); tick();
    chk("R1 addr after reset", 32'(cur_addr), 32'h0);
    chk("R1 last_beat after reset", 32'(last_beat), 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_load_pri();
    load(1'b1, 1'b0, 17'h0_ABC5);
    chk("R2 primary load", 32'(cur_addr), 32'h0ABC5);
    chk("R10 last clear after load", 32'(last_beat), 32'h0);
  endtask

  task automatic t_load_sec();
    load(1'b0, 1'b1, 17'h1_2342);
    chk("R3 secondary load", 32'(cur_addr), 32'h12342);
  endtask

  task automatic t_both();
    logic [AW-1:0] a;
    a = 17'h0_7777;
    load(1'b1, 1'b0, a);
    adv_en = 1'b1; tick(); idle();
    start_pri = 1'b1; start_sec = 1'b1; adv_en = 1'b1; addr_in = 17'h0_0F0D;
    tick(); idle();
    chk("R4 both strobes with advance", 32'(cur_addr), 32'h00F0D);
    chk("R4 beat restarted, last low", 32'(last_beat), 32'h0);
  endtask

  task automatic t_walk(logic lin, string tag);
    logic [AW-1:0] a;
    a = 17'h0_ABC5;
    lin_order = lin;
    load(1'b1, 1'b0, a);
    for (int i = 1; i <= 4; i++) begin
      adv_en = 1'b1; tick(); idle();
      chk(tag, 32'(cur_addr), 32'(expect_addr(a, i, lin)));
      chk("R10 last_beat flag", 32'(last_beat), 32'((i % 4) == 3));
    end
    chk("R9 wrapped to start", 32'(cur_addr), 32'(a));
  endtask

  task automatic t_hold();
    logic [AW-1:0] a;
    a = 17'h1_FFFE;
    lin_order = 1'b1;
    load(1'b0, 1'b1, a);
    adv_en = 1'b1; tick(); idle();
    tick(); tick();
    chk("R5 hold without advance", 32'(cur_addr), 32'(expect_addr(a, 1, 1'b1)));
    adv_en = 1'b1; tick(); idle();
    chk("R5 step after hold", 32'(cur_addr), 32'(expect_addr(a, 2, 1'b1)));
    chk("R9 upper bits kept past wrap", 32'(cur_addr[AW-1:2]), 32'(a[AW-1:2]));
  endtask

  task automatic t_mode_async();
    logic [AW-1:0] a;
    a = 17'h0_3331;
    lin_order = 1'b1;
    load(1'b1, 1'b0, a);
    adv_en = 1'b1; tick(); idle();
    chk("R6 linear beat 1", 32'(cur_addr), 32'(expect_addr(a, 1, 1'b1)));
    #2 lin_order = 1'b0;
    #1 chk("R8 unclocked switch to interleaved", 32'(cur_addr), 32'(expect_addr(a, 1, 1'b0)));
    #1 lin_order = 1'b1;
    #1 chk("R8 unclocked switch back", 32'(cur_addr), 32'(expect_addr(a, 1, 1'b1)));
  endtask

  initial begin
    t_reset();
    t_load_pri();
    t_load_sec();
    t_both();
    t_walk(1'b1, "R6 linear order");
    t_walk(1'b0, "R7 interleaved order");
    t_hold();
    t_mode_async();
    tick();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule